// File: doc/BRIEF.md
# Pipelined-Address Bus Cycle Sequencer

This block is the phase controller for a processor's external bus. Each clock it looks at four inputs: a level flag from the core saying that a bus transfer is wanted, an external hold request, an active-low cycle-termination input and an active-low early next-address input. From these it picks one of seven bus phases. It supports address pipelining. When the system signals that the next address may be driven early, the controller moves into an overlap phase. If the core already has another transfer queued, the next address is issued while the current data phase is still open. The new cycle then begins in a pipelined first-clock phase, without passing through idle.

The outputs are the current phase as a one-hot vector, a one-clock address strobe, a hold-acknowledge level and a combinational cycle-done strobe. A transfer request that arrives while the bus is idle or granted away is remembered. It is issued on the first normal cycle after the hold is released. Address, data, byte-enable and wait-state logic lie outside this block.

Top module: `bus_cycle_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle phase. `phase_o` is one-hot with bit 0 idle, bit 1 hold-granted, bit 2 first clock, bit 3 data, bit 4 early-address-no-request, bit 5 early-address-with-request and bit 6 pipelined first clock. Exactly one bit is set at all times.
- R2: From idle or hold-granted, the next phase is hold-granted while `hold_req_i` is 1. With hold low it is first clock if a request is pending, and idle otherwise.
- R3: The first-clock phase always moves to the data phase on the next clock, whatever the inputs.
- R4: In the data phase or in early-address-no-request, `rdy_n_i`=0 ends the cycle. The next phase is hold-granted if hold is 1, first clock if hold is 0 with a request, and idle otherwise.
- R5: In the data phase with `rdy_n_i`=1, the phase stays while `nxt_addr_n_i`=1. With `nxt_addr_n_i`=0 it moves to early-address-with-request when hold is 0 and a request is pending, and to early-address-no-request otherwise.
- R6: In early-address-no-request with `rdy_n_i`=1, the phase stays there until a request is pending with hold 0, then moves to early-address-with-request. `nxt_addr_n_i` has no effect there.
- R7: Early-address-with-request stays while `rdy_n_i`=1 and moves to pipelined first clock when `rdy_n_i`=0.
- R8: From pipelined first clock, `nxt_addr_n_i`=1 leads to the data phase. `nxt_addr_n_i`=0 leads to early-address-with-request when hold is 0 and a request is pending, and to early-address-no-request otherwise.
- R9: `addr_strobe_o` is 1 throughout first clock and on the first clock of each stay in early-address-with-request only. It is 0 in every other clock.
- R10: `cycle_done_o` is 1 in the same clock that `rdy_n_i`=0 is presented in the data, early-address-no-request or early-address-with-request phase, and 0 otherwise.
- R11: `hold_ack_o` is 1 exactly when the phase is hold-granted.
- R12: A request pulse on `bus_req_i` seen in idle or hold-granted is kept until the block enters first clock, even if `bus_req_i` has dropped by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Core has a transfer pending |
| hold_req_i | input | 1 | External request for the bus |
| rdy_n_i | input | 1 | Active-low cycle termination |
| nxt_addr_n_i | input | 1 | Active-low permission to drive the next address early |
| phase_o | output | 7 | One-hot current bus phase |
| addr_strobe_o | output | 1 | Address valid strobe |
| hold_ack_o | output | 1 | Bus granted to the external requester |
| cycle_done_o | output | 1 | Current cycle terminates this clock |

## Verification
Any wrong phase is visible on `phase_o` one clock after the edge that chose it, because the one-hot vector is the state register itself. Damage to the remembered request shows up one edge after hold is released: the block goes to idle instead of first clock. A strobe fault can hide inside a long overlap phase, so the bench holds early-address-with-request for two clocks and checks the strobe in the second one. `cycle_done_o` is combinational, so it is checked within the same clock that termination is presented.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int NUM_PH = 7;

    localparam int IX_IDLE = 0;
    localparam int IX_HOLD = 1;
    localparam int IX_FST  = 2;
    localparam int IX_DATA = 3;
    localparam int IX_EANR = 4;
    localparam int IX_EAWR = 5;
    localparam int IX_PFST = 6;

    typedef enum logic [NUM_PH-1:0] {
        PH_IDLE = 7'b0000001,
        PH_HOLD = 7'b0000010,
        PH_FST  = 7'b0000100,
        PH_DATA = 7'b0001000,
        PH_EANR = 7'b0010000,
        PH_EAWR = 7'b0100000,
        PH_PFST = 7'b1000000
    } bus_phase_e;

    // Inputs converted to active-high meaning
    typedef struct packed {
        logic want;    // request pending (raw or remembered)
        logic hold;    // hold requested
        logic ready;   // cycle termination
        logic early;   // next address may be driven
    } bus_in_t;

    function automatic logic can_issue(input bus_in_t s);
        return s.want && !s.hold;
    endfunction

    // Phase chosen when a cycle ends or the bus is free
    function automatic bus_phase_e settle(input bus_in_t s);
        if (s.hold)         return PH_HOLD;
        else if (s.want)    return PH_FST;
        else                return PH_IDLE;
    endfunction

    // Phase chosen once an early address has been granted
    function automatic bus_phase_e overlap(input bus_in_t s);
        return can_issue(s) ? PH_EAWR : PH_EANR;
    endfunction

endpackage

// File: rtl/bcs_req_latch.sv
module bcs_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic parked_i,   // current phase is idle or hold-granted
    input  logic issue_i,    // next phase is first clock
    output logic want_o
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= 1'b0;
        else if (parked_i)
            held_q <= issue_i ? 1'b0 : (held_q | req_i);
    end

    assign want_o = req_i | held_q;
endmodule

// File: rtl/bcs_next_state.sv
module bcs_next_state
    import bcs_pkg::*;
(
    input  bus_phase_e cur_i,
    input  bus_in_t    in_i,
    output bus_phase_e nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            PH_IDLE, PH_HOLD: nxt_o = settle(in_i);
            PH_FST:           nxt_o = PH_DATA;
            PH_DATA: begin
                if (in_i.ready)      nxt_o = settle(in_i);
                else if (in_i.early) nxt_o = overlap(in_i);
                else                 nxt_o = PH_DATA;
            end
            PH_EANR: begin
                if (in_i.ready)          nxt_o = settle(in_i);
                else if (can_issue(in_i)) nxt_o = PH_EAWR;
                else                     nxt_o = PH_EANR;
            end
            PH_EAWR:          nxt_o = in_i.ready ? PH_PFST : PH_EAWR;
            PH_PFST:          nxt_o = in_i.early ? overlap(in_i) : PH_DATA;
            default:          nxt_o = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/bcs_out_decode.sv
module bcs_out_decode
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_phase_e cur_i,
    input  logic       ready_i,
    output logic       strobe_o,
    output logic       hack_o,
    output logic       done_o
);
    logic was_eawr_q;

    always_ff @(posedge clk) begin
        if (rst) was_eawr_q <= 1'b0;
        else     was_eawr_q <= (cur_i == PH_EAWR);
    end

    always_comb begin
        strobe_o = (cur_i == PH_FST) || ((cur_i == PH_EAWR) && !was_eawr_q);
        hack_o   = (cur_i == PH_HOLD);
        done_o   = ready_i &&
                   ((cur_i == PH_DATA) || (cur_i == PH_EANR) || (cur_i == PH_EAWR));
    end
endmodule

// File: rtl/bus_cycle_sequencer.sv
module bus_cycle_sequencer
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req_i,
    input  logic              hold_req_i,
    input  logic              rdy_n_i,
    input  logic              nxt_addr_n_i,
    output logic [NUM_PH-1:0] phase_o,
    output logic              addr_strobe_o,
    output logic              hold_ack_o,
    output logic              cycle_done_o
);
    bus_phase_e phase_q, phase_d;
    bus_in_t    sampled;
    logic       want;

    bcs_req_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .req_i    (bus_req_i),
        .parked_i ((phase_q == PH_IDLE) || (phase_q == PH_HOLD)),
        .issue_i  (phase_d == PH_FST),
        .want_o   (want)
    );

    always_comb begin
        sampled.want  = want;
        sampled.hold  = hold_req_i;
        sampled.ready = !rdy_n_i;
        sampled.early = !nxt_addr_n_i;
    end

    bcs_next_state u_next (
        .cur_i (phase_q),
        .in_i  (sampled),
        .nxt_o (phase_d)
    );

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    bcs_out_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .cur_i    (phase_q),
        .ready_i  (sampled.ready),
        .strobe_o (addr_strobe_o),
        .hack_o   (hold_ack_o),
        .done_o   (cycle_done_o)
    );

    assign phase_o = phase_q;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
    import bcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_req_i,
    input logic              hold_req_i,
    input logic              rdy_n_i,
    input logic              nxt_addr_n_i,
    input logic [NUM_PH-1:0] phase_o,
    input logic              addr_strobe_o,
    input logic              hold_ack_o,
    input logic              cycle_done_o
);
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> phase_o == 7'b0000001);
    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_o) == 1);
    p_hold_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o[IX_IDLE] || phase_o[IX_HOLD]) && hold_req_i |=> phase_o[IX_HOLD]);
    p_first_to_data_r3: assert property (@(posedge clk) disable iff (rst)
        phase_o[IX_FST] |=> phase_o[IX_DATA]);
    p_data_wait_r5: assert property (@(posedge clk) disable iff (rst)
        phase_o[IX_DATA] && rdy_n_i && nxt_addr_n_i |=> phase_o[IX_DATA]);
    p_eanr_stay_r6: assert property (@(posedge clk) disable iff (rst)
        phase_o[IX_EANR] && rdy_n_i && hold_req_i |=> phase_o[IX_EANR]);
    p_eawr_stay_r7: assert property (@(posedge clk) disable iff (rst)
        phase_o[IX_EAWR] && rdy_n_i |=> phase_o[IX_EAWR]);
    p_eawr_exit_r7: assert property (@(posedge clk) disable iff (rst)
        phase_o[IX_EAWR] && !rdy_n_i |=> phase_o[IX_PFST]);
    p_pfst_plain_r8: assert property (@(posedge clk) disable iff (rst)
        phase_o[IX_PFST] && nxt_addr_n_i |=> phase_o[IX_DATA]);
    p_strobe_where_r9: assert property (@(posedge clk) disable iff (rst)
        addr_strobe_o |-> (phase_o[IX_FST] || phase_o[IX_EAWR]));
    p_strobe_once_r9: assert property (@(posedge clk) disable iff (rst)
        phase_o[IX_EAWR] && $past(phase_o[IX_EAWR]) |-> !addr_strobe_o);
    p_done_where_r10: assert property (@(posedge clk) disable iff (rst)
        cycle_done_o |-> !rdy_n_i &&
            (phase_o[IX_DATA] || phase_o[IX_EANR] || phase_o[IX_EAWR]));
    p_hack_where_r11: assert property (@(posedge clk) disable iff (rst)
        hold_ack_o |-> phase_o[IX_HOLD]);
endmodule

bind bus_cycle_sequencer bcs_checker u_bcs_checker (
    .clk           (clk),
    .rst           (rst),
    .bus_req_i     (bus_req_i),
    .hold_req_i    (hold_req_i),
    .rdy_n_i       (rdy_n_i),
    .nxt_addr_n_i  (nxt_addr_n_i),
    .phase_o       (phase_o),
    .addr_strobe_o (addr_strobe_o),
    .hold_ack_o    (hold_ack_o),
    .cycle_done_o  (cycle_done_o)
);

// File: tb/bus_cycle_sequencer_bench.sv
module bus_cycle_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0, hold = 1'b0, rdy_n = 1'b1, na_n = 1'b1;
    logic [6:0] phase;
    logic       ads, hack, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    bus_cycle_sequencer u_bus_cycle_sequencer (
        .clk(clk), .rst(rst), .bus_req_i(req), .hold_req_i(hold),
        .rdy_n_i(rdy_n), .nxt_addr_n_i(na_n), .phase_o(phase),
        .addr_strobe_o(ads), .hold_ack_o(hack), .cycle_done_o(done)
    );

    // Phase codes: 0 idle, 1 hold-granted, 2 first, 3 data,
    // 4 early-no-req, 5 early-with-req, 6 pipelined first
    // Vector: [8] req [7] hold [6] rdy_n [5] na_n [4] ads now [3] done now [2:0] next phase
    localparam int NV = 36;
    localparam logic [8:0] VEC [NV] = '{
        9'b0011_00_000, 9'b1011_00_010, 9'b0100_10_011, 9'b0011_00_011,
        9'b1001_01_010, 9'b0011_10_011, 9'b1010_00_101, 9'b1011_10_101,
        9'b0001_01_110, 9'b0011_00_011, 9'b0010_00_100, 9'b0011_00_100,
        9'b1110_00_100, 9'b1011_00_101, 9'b0001_11_110, 9'b0010_00_100,
        9'b0101_01_001, 9'b1111_00_001, 9'b0011_00_010, 9'b0011_10_011,
        9'b0001_01_000, 9'b0111_00_001, 9'b0011_00_000, 9'b1011_00_010,
        9'b1111_10_011, 9'b1110_00_100, 9'b1101_01_001, 9'b0011_00_000,
        9'b1011_00_010, 9'b1011_10_011, 9'b1010_00_101, 9'b1001_11_110,
        9'b1010_00_101, 9'b0001_11_110, 9'b0110_00_100, 9'b0001_01_000
    };

    function automatic string tag_for(input int cur, input logic ry_n);
        case (cur)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return ry_n ? "R5" : "R4";
            4:       return ry_n ? "R6" : "R4";
            5:       return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic h, input logic y, input logic n);
        @(negedge clk);
        req = r; hold = h; rdy_n = y; na_n = n;
    endtask

    initial begin
        int cur = 0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "phase in reset", phase, 7'b0000001);
        check("R11", "hold_ack in reset", {6'b0, hack}, 7'b0);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [8:0] v = VEC[i];
            int nxt = int'(v[2:0]);
            string tg = tag_for(cur, v[6]);
            step(v[8], v[7], v[6], v[5]);
            #1;
            check("R9", $sformatf("strobe step %0d", i), {6'b0, ads}, {6'b0, v[4]});
            check("R10", $sformatf("done step %0d", i), {6'b0, done}, {6'b0, v[3]});
            @(posedge clk);
            #1;
            check(tg, $sformatf("phase step %0d", i), phase, 7'(1 << nxt));
            check("R11", $sformatf("hold_ack step %0d", i), {6'b0, hack},
                  {6'b0, (nxt == 1) ? 1'b1 : 1'b0});
            cur = nxt;
        end

        // R12: request pulse during hold, released with request already gone
        step(0, 1, 1, 1); @(posedge clk); #1;
        check("R2", "enter hold", phase, 7'b0000010);
        step(1, 1, 1, 1); @(posedge clk);
        step(0, 1, 1, 1); @(posedge clk);
        step(0, 0, 1, 1); @(posedge clk); #1;
        check("R12", "remembered request issues", phase, 7'b0000100);
        step(0, 0, 1, 1); @(posedge clk);
        step(0, 0, 0, 1); @(posedge clk); #1;
        check("R12", "request consumed once", phase, 7'b0000001);

        // R1: reset in the middle of an overlapped cycle
        step(1, 0, 1, 1); @(posedge clk);
        step(1, 0, 1, 1); @(posedge clk);
        step(1, 0, 1, 0); @(posedge clk); #1;
        check("R5", "reach early-with-request", phase, 7'b0100000);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        check("R1", "mid-cycle reset", phase, 7'b0000001);
        check("R9", "no strobe after reset", {6'b0, ads}, 7'b0);
        @(negedge clk) rst = 1'b0; req = 0;
        @(posedge clk); #1;
        check("R1", "idle after reset release", phase, 7'b0000001);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule